// File: doc/BRIEF.md
# Noise-Filtered Timer Input Edge Detector

This block conditions one external timer input pin. The pin can drive a counter as its count source, or it can request a capture. The raw pin first passes through a synchronizer on the system clock. The synchronized level is then sampled, but only on a one-cycle sampling strobe, and the strobe depends on how the input is used:

- As a count source, the pin is sampled on a strobe running at one quarter of the system clock.
- As a capture trigger, it is sampled on the counter's selected count clock strobe.

A level change is accepted only once two successive samples agree on the new level. This rejects short noise pulses.

The block compares the accepted (filtered) level with a stored reference level. When they differ in the programmed direction (rising, falling or both), it raises a pulse for one system-clock cycle:

- In count-source mode the pulse goes out on the count output.
- In capture mode it goes out on the capture request output, unless the associated register is in compare mode.

The stored reference starts low after reset. As a result, a pin that is already high fires one rising edge on the first enable. After a stop and a restart, the reference follows the filtered pin level, so a restart with the pin high reports nothing.

Top module: `tmr_edge_filter`

## Requirements
- R1: A new pin level is accepted only after two consecutive sampling strobes both see it (after a two-flop synchronizer). A pin pulse shorter than one sampling interval produces no edge output.
- R2: With useCapture = 0 only quarterStrobe samples the pin. With useCapture = 1 only countStrobe samples it. The strobe not selected has no effect on the outputs.
- R3: Edge-select encoding: edgeSel = 2'b00 reports falling edges, 2'b01 rising edges, 2'b11 both, and 2'b10 no edges at all.
- R4: Each detected edge gives a pulse exactly one system-clock cycle wide, starting in the cycle after the filtered level changes.
- R5: After reset the reference level is low. If the pin is already high when the timer is first enabled, with rising or both selected, exactly one rising edge is reported.
- R6: If the timer is disabled and then enabled again while the pin is high, no edge is reported. While the timer is off after its first enable, the reference is loaded from the filtered level.
- R7: While timerEn = 0, no pulse appears on either output, whatever the pin does.
- R8: countEdge pulses only when useCapture = 0. captureReq pulses only when useCapture = 1 and compareMode = 0. With compareMode = 1 no capture request is issued.
- R9: During reset both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | 1 | Raw asynchronous timer input pin |
| timerEn | input | 1 | Timer operation enable |
| useCapture | input | 1 | 0: pin is the count source, 1: pin is a capture trigger |
| edgeSel | input | 2 | Valid-edge select (00 fall, 01 rise, 10 none, 11 both) |
| quarterStrobe | input | 1 | One-cycle strobe at a quarter of the system clock |
| countStrobe | input | 1 | One-cycle strobe at the selected count clock |
| compareMode | input | 1 | Associated register is in compare mode; blocks capture requests |
| countEdge | output | 1 | One-cycle count pulse on a valid edge (count-source mode) |
| captureReq | output | 1 | One-cycle capture request on a valid edge (capture mode) |

## Verification
The hardest case to reach is the one-time rising edge after reset. It needs the filtered level to rise while the timer has never been enabled, and then an enable with no further pin activity. The bench holds the pin high through reset and lets the filter settle with the timer off. It then enables the timer and counts exactly one pulse. Next it stops and restarts the timer with the pin unchanged and expects silence.

The strobe selection is isolated in a similar way. The bench freezes one strobe generator while the pin changes, and the edge appears only once the selected strobe resumes.

// File: rtl/tef_pkg.sv
package tef_pkg;

  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_NONE = 2'b10,
    EDGE_BOTH = 2'b11
  } edgeSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic sampleEn;  // take one filter sample this cycle
    logic loadRef;   // copy filtered level into reference
  } dpStrobe_t;

endpackage

// File: rtl/tef_datapath.sv
module tef_datapath
  import tef_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int FILTER_SAMPLES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      pinIn,
  input  dpStrobe_t strobe,
  output logic      filtLevel,
  output logic      refLevel
);

  logic [SYNC_STAGES-1:0]    syncQ;
  logic [FILTER_SAMPLES-1:0] hist;
  logic [FILTER_SAMPLES-1:0] newHist;
  logic                      synced;

  assign synced  = syncQ[SYNC_STAGES-1];
  assign newHist = {hist[FILTER_SAMPLES-2:0], synced};

  // Synchronizer chain on the system clock
  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], pinIn};
  end

  // Sample history; level accepted when the whole window agrees
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hist      <= '0;
      filtLevel <= 1'b0;
    end else if (strobe.sampleEn) begin
      hist <= newHist;
      if (&newHist)      filtLevel <= 1'b1;
      else if (~|newHist) filtLevel <= 1'b0;
    end
  end

  // Reference level for edge comparison; starts low after reset
  always_ff @(posedge clk) begin
    if (!rstN)              refLevel <= 1'b0;
    else if (strobe.loadRef) refLevel <= filtLevel;
  end

endmodule

// File: rtl/tef_control.sv
module tef_control
  import tef_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      timerEn,
  input  logic      useCapture,
  input  logic [1:0] edgeSel,
  input  logic      quarterStrobe,
  input  logic      countStrobe,
  input  logic      compareMode,
  input  logic      filtLevel,
  input  logic      refLevel,
  output dpStrobe_t strobe,
  output logic      countEdge,
  output logic      captureReq
);

  logic     everEnabled;
  logic     isRise;
  logic     isFall;
  logic     hit;
  edgeSel_e selMode;

  assign selMode = edgeSel_e'(edgeSel);

  // Set at first enable; before it the reference holds its reset value
  always_ff @(posedge clk) begin
    if (!rstN)        everEnabled <= 1'b0;
    else if (timerEn) everEnabled <= 1'b1;
  end

  always_comb begin
    strobe.sampleEn = useCapture ? countStrobe : quarterStrobe;
    strobe.loadRef  = timerEn | everEnabled;
  end

  assign isRise = filtLevel & ~refLevel;
  assign isFall = ~filtLevel & refLevel;

  always_comb begin
    unique case (selMode)
      EDGE_RISE: hit = isRise;
      EDGE_FALL: hit = isFall;
      EDGE_BOTH: hit = isRise | isFall;
      default:   hit = 1'b0;
    endcase
    hit = hit & timerEn;
  end

  assign countEdge  = hit & ~useCapture;
  assign captureReq = hit & useCapture & ~compareMode;

endmodule

// File: rtl/tmr_edge_filter.sv
module tmr_edge_filter
  import tef_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int FILTER_SAMPLES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pinIn,
  input  logic       timerEn,
  input  logic       useCapture,
  input  logic [1:0] edgeSel,
  input  logic       quarterStrobe,
  input  logic       countStrobe,
  input  logic       compareMode,
  output logic       countEdge,
  output logic       captureReq
);

  dpStrobe_t strobe;
  logic      filtLevel;
  logic      refLevel;

  tef_datapath #(
    .SYNC_STAGES   (SYNC_STAGES),
    .FILTER_SAMPLES(FILTER_SAMPLES)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .pinIn    (pinIn),
    .strobe   (strobe),
    .filtLevel(filtLevel),
    .refLevel (refLevel)
  );

  tef_control u_control (
    .clk          (clk),
    .rstN         (rstN),
    .timerEn      (timerEn),
    .useCapture   (useCapture),
    .edgeSel      (edgeSel),
    .quarterStrobe(quarterStrobe),
    .countStrobe  (countStrobe),
    .compareMode  (compareMode),
    .filtLevel    (filtLevel),
    .refLevel     (refLevel),
    .strobe       (strobe),
    .countEdge    (countEdge),
    .captureReq   (captureReq)
  );

endmodule

// File: rtl/tmr_edge_filter_chk.sv
module tmr_edge_filter_chk (
  input logic       clk,
  input logic       rstN,
  input logic       timerEn,
  input logic       useCapture,
  input logic [1:0] edgeSel,
  input logic       compareMode,
  input logic       countEdge,
  input logic       captureReq
);

  assert_count_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    countEdge |=> !countEdge);

  assert_capture_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    captureReq |=> !captureReq);

  assert_quiet_disabled_R7: assert property (@(posedge clk) disable iff (!rstN)
    !timerEn |-> (!countEdge && !captureReq));

  assert_none_select_R3: assert property (@(posedge clk) disable iff (!rstN)
    (edgeSel == 2'b10) |-> (!countEdge && !captureReq));

  assert_compare_block_R8: assert property (@(posedge clk) disable iff (!rstN)
    compareMode |-> !captureReq);

  assert_mode_route_R8: assert property (@(posedge clk) disable iff (!rstN)
    (useCapture |-> !countEdge) and (!useCapture |-> !captureReq));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      assert_reset_quiet_R9: assert (!countEdge && !captureReq);
    end
  end

endmodule

bind tmr_edge_filter tmr_edge_filter_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .timerEn    (timerEn),
  .useCapture (useCapture),
  .edgeSel    (edgeSel),
  .compareMode(compareMode),
  .countEdge  (countEdge),
  .captureReq (captureReq)
);

// File: tb/tmr_edge_filter_tb.sv
`timescale 1ns/1ps
module tmr_edge_filter_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pinIn = 1'b0;
  logic       timerEn = 1'b0;
  logic       useCapture = 1'b0;
  logic [1:0] edgeSel = 2'b01;
  logic       quarterStrobe = 1'b0;
  logic       countStrobe = 1'b0;
  logic       compareMode = 1'b0;
  logic       countEdge;
  logic       captureReq;

  logic qRun = 1'b1;
  logic cRun = 1'b1;
  int   phase = 0;

  int total = 0;
  int bad = 0;
  int nCount = 0;
  int nCap = 0;
  int runLen = 0;
  int maxRun = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_edge_filter u_dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .timerEn(timerEn),
    .useCapture(useCapture), .edgeSel(edgeSel),
    .quarterStrobe(quarterStrobe), .countStrobe(countStrobe),
    .compareMode(compareMode), .countEdge(countEdge), .captureReq(captureReq)
  );

  // Strobe generators: quarter every 4 cycles, count clock every 2 cycles
  always @(posedge clk) begin
    #1;
    phase = (phase + 1) % 4;
    quarterStrobe = qRun && (phase == 3);
    countStrobe   = cRun && (phase[0] == 1'b1);
  end

  // Pulse monitor, sampled at the falling edge
  always @(negedge clk) begin
    if (rstN) begin
      if (countEdge)  nCount++;
      if (captureReq) nCap++;
      if (countEdge || captureReq) begin
        runLen++;
        if (runLen > maxRun) maxRun = runLen;
      end else begin
        runLen = 0;
      end
    end
  end

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic clearCounts();
    nCount = 0;
    nCap = 0;
  endtask

  task automatic testReset();
    pinIn = 1'b1;
    rstN = 1'b0;
    waitCyc(4);
    @(negedge clk);
    check("R9 countEdge in reset", countEdge, 0);
    check("R9 captureReq in reset", captureReq, 0);
    waitCyc(1);
    rstN = 1'b1;
  endtask

  task automatic testFirstEnable();
    clearCounts();
    waitCyc(30);
    check("R7 no pulse before first enable", nCount, 0);
    timerEn = 1'b1;
    waitCyc(10);
    check("R5 one rising edge on first enable", nCount, 1);
  endtask

  task automatic testRestart();
    timerEn = 1'b0;
    waitCyc(8);
    clearCounts();
    timerEn = 1'b1;
    waitCyc(12);
    check("R6 no edge after restart with pin high", nCount, 0);
  endtask

  task automatic edgeCase(input logic [1:0] sel, input int exp, input string req);
    edgeSel = sel;
    clearCounts();
    pinIn = 1'b1;
    waitCyc(24);
    pinIn = 1'b0;
    waitCyc(24);
    check(req, nCount, exp);
  endtask

  task automatic testEdges();
    pinIn = 1'b0;
    waitCyc(24);
    edgeCase(2'b01, 1, "R3 rise select");
    edgeCase(2'b00, 1, "R3 fall select");
    edgeCase(2'b11, 2, "R3 both select");
    edgeCase(2'b10, 0, "R3 none select");
  endtask

  task automatic testGlitch();
    edgeSel = 2'b11;
    clearCounts();
    pinIn = 1'b1;
    waitCyc(2);
    pinIn = 1'b0;
    waitCyc(24);
    check("R1 short pulse rejected", nCount, 0);
    pinIn = 1'b1;
    waitCyc(24);
    check("R1 long level accepted", nCount, 1);
    pinIn = 1'b0;
    waitCyc(24);
  endtask

  task automatic testDisabled();
    timerEn = 1'b0;
    clearCounts();
    for (int i = 0; i < 3; i++) begin
      pinIn = 1'b1;
      waitCyc(20);
      pinIn = 1'b0;
      waitCyc(20);
    end
    check("R7 count pulses while disabled", nCount, 0);
    check("R7 capture pulses while disabled", nCap, 0);
    timerEn = 1'b1;
    waitCyc(12);
    check("R6 re-enable with pin low silent", nCount, 0);
  endtask

  task automatic testStrobeSelect();
    edgeSel = 2'b01;
    useCapture = 1'b0;
    qRun = 1'b0;
    cRun = 1'b1;
    clearCounts();
    pinIn = 1'b1;
    waitCyc(24);
    check("R2 count mode ignores countStrobe", nCount, 0);
    qRun = 1'b1;
    waitCyc(24);
    check("R2 count mode edge on quarterStrobe", nCount, 1);
    pinIn = 1'b0;
    waitCyc(24);
    useCapture = 1'b1;
    cRun = 1'b0;
    clearCounts();
    pinIn = 1'b1;
    waitCyc(24);
    check("R2 capture mode ignores quarterStrobe", nCap, 0);
    cRun = 1'b1;
    waitCyc(24);
    check("R2 capture mode edge on countStrobe", nCap, 1);
    check("R8 no count pulse in capture mode", nCount, 0);
    pinIn = 1'b0;
    waitCyc(24);
  endtask

  task automatic testCompare();
    useCapture = 1'b1;
    compareMode = 1'b1;
    edgeSel = 2'b11;
    clearCounts();
    pinIn = 1'b1;
    waitCyc(24);
    pinIn = 1'b0;
    waitCyc(24);
    check("R8 compare mode blocks capture", nCap, 0);
    check("R8 compare mode no count pulse", nCount, 0);
    compareMode = 1'b0;
    clearCounts();
    pinIn = 1'b1;
    waitCyc(24);
    check("R8 capture resumes after compare off", nCap, 1);
    useCapture = 1'b0;
  endtask

  initial begin
    testReset();
    testFirstEnable();
    testRestart();
    testEdges();
    testGlitch();
    testDisabled();
    testStrobeSelect();
    testCompare();
    check("R4 pulse width one cycle", maxRun, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule